// File: doc/BRIEF.md
# DMA Channel Event Flag Bank

This block keeps the per-channel event flags of a multi-channel DMA controller. Each channel's transfer engine sends single-cycle pulses for three events: a transfer error, the halfway point of a transfer, and the end of a transfer. The block latches each pulse into a sticky flag. It also latches a per-channel summary flag that is set whenever any of the three events occurs.

Software sees the flags through a read-only status word on a simple register bus. It clears them by writing ones to a separate clear word that uses the same bit layout. Each channel drives a registered interrupt line. The line is high while any latched event flag is set whose matching enable input is high.

The channel count is a parameter from 1 to 7. Status bits that belong to channels the instance does not have read as zero.

Top module: `dma_flag_bank`

## Requirements
- R1: After a synchronous reset every flag is 0, every `irq` bit is 0 and `bus_rdata` is 0.
- R2: The status word at address `STATUS_ADDR` (default 0x0) gives channel c the bits 4c+3..4c, where c counts from 0. Within that nibble, bit 0 is the summary flag, bit 1 is end-of-transfer, bit 2 is halfway and bit 3 is error. Bits 31:28 and the nibbles of channels at or above `NUM_CH` always read 0. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`.
- R3: A pulse on `ev_err[c]`, `ev_half[c]` or `ev_done[c]` sets the matching flag of channel c on the clock edge that samples it. The flag then holds until it is cleared.
- R4: Any of the three event pulses on channel c also sets that channel's summary flag on the same edge.
- R5: A write to `CLEAR_ADDR` (default 0x4) clears each flag whose bit is 1 in the written word, using the R2 layout. Bits written as 0 leave their flags unchanged.
- R6: Writing 1 to the summary bit of channel c in the clear word clears all four flags of that channel.
- R7: If an event pulse and a clear of the same flag land on the same edge, the flag ends up set.
- R8: A write to the status address changes no flag.
- R9: A read of the clear address returns 0.
- R10: `irq[c]` is registered and changes on the same edge as the flags. It is the OR of (error flag AND `en_err[c]`), (halfway flag AND `en_half[c]`) and (end flag AND `en_done[c]`). It stays high until the enabled flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_err | input | NUM_CH | Transfer-error pulse per channel |
| ev_half | input | NUM_CH | Halfway pulse per channel |
| ev_done | input | NUM_CH | End-of-transfer pulse per channel |
| en_err | input | NUM_CH | Interrupt enable for the error flag |
| en_half | input | NUM_CH | Interrupt enable for the halfway flag |
| en_done | input | NUM_CH | Interrupt enable for the end flag |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
A flag that is stuck or lost shows up on the next status read, one edge after the read strobe. A stuck or lost flag also shows on `irq` on the edge after the event or clear, provided the matching enable is high. A wrong nibble layout or a wrong clear decode moves the disturbance to another channel's bits, so every test reads back the whole word and compares it against a value computed from R2. A set-versus-clear priority error shows as a zero nibble after the collision cycle. Reserved bits and absent-channel bits are checked on a 7-channel instance and a 5-channel instance driven by the same stimulus.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
  localparam int MAX_CH = 7;
  localparam int NIB_W  = 4;
  localparam int WORD_W = 32;

  // packed from MSB: error, halfway, end, summary -> nibble bits 3..0
  typedef struct packed {
    logic err;
    logic half;
    logic done;
    logic glob;
  } ch_flags_t;
endpackage

// File: rtl/dma_flag_chan.sv
module dma_flag_chan
  import dma_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_err,
  input  logic      ev_half,
  input  logic      ev_done,
  input  ch_flags_t clr,
  input  logic      en_err,
  input  logic      en_half,
  input  logic      en_done,
  output ch_flags_t flags,
  output logic      irq
);
  ch_flags_t nxt;
  logic      any_ev;
  logic      irq_n;

  always_comb begin
    any_ev   = ev_err | ev_half | ev_done;
    // set has priority over clear; summary clear wipes the whole channel
    nxt.err  = ev_err  | (flags.err  & ~(clr.err  | clr.glob));
    nxt.half = ev_half | (flags.half & ~(clr.half | clr.glob));
    nxt.done = ev_done | (flags.done & ~(clr.done | clr.glob));
    nxt.glob = any_ev  | (flags.glob & ~clr.glob);
    irq_n    = (nxt.err & en_err) | (nxt.half & en_half) | (nxt.done & en_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nxt;
      irq   <= irq_n;
    end
  end

  a_r3_err_sets: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> flags.err);
  a_r3_half_sets: assert property (@(posedge clk) disable iff (rst)
    ev_half |=> flags.half);
  a_r3_done_sets: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> flags.done);
  a_r4_summary_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_err || ev_half || ev_done) |=> flags.glob);
  a_r6_summary_clear: assert property (@(posedge clk) disable iff (rst)
    (clr.glob && !ev_err && !ev_half && !ev_done) |=> (flags == '0));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clr == '0 && !ev_err && !ev_half && !ev_done) |=> $stable(flags));
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flags.err || flags.half || flags.done));
endmodule

// File: rtl/dma_flag_regif.sv
module dma_flag_regif
  import dma_flag_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] status_word,
  output logic [WORD_W-1:0] clr_word,
  output logic [WORD_W-1:0] bus_rdata
);
  logic hit_status;
  logic hit_clear;

  always_comb begin
    hit_status = (bus_addr == STATUS_ADDR);
    hit_clear  = (bus_addr == CLEAR_ADDR);
    clr_word   = (bus_wr && hit_clear) ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= hit_status ? status_word : '0;
    end
  end

  a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_clear) |=> (bus_rdata == '0));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_status) |=> (bus_rdata[WORD_W-1:WORD_W-NIB_W] == '0));
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
  import dma_flag_pkg::*;
#(
  parameter int               NUM_CH      = 7,
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] ev_err,
  input  logic [NUM_CH-1:0] ev_half,
  input  logic [NUM_CH-1:0] ev_done,
  input  logic [NUM_CH-1:0] en_err,
  input  logic [NUM_CH-1:0] en_half,
  input  logic [NUM_CH-1:0] en_done,
  output logic [NUM_CH-1:0] irq
);
  localparam int USED_W = MAX_CH * NIB_W;
  localparam int SPARE_W = WORD_W - USED_W;

  logic [MAX_CH-1:0][NIB_W-1:0] stat_nib;
  logic [WORD_W-1:0]            status_word;
  logic [WORD_W-1:0]            clr_word;

  assign status_word = {{SPARE_W{1'b0}}, stat_nib};

  dma_flag_regif #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .CLEAR_ADDR  (CLEAR_ADDR)
  ) regif_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .status_word (status_word),
    .clr_word    (clr_word),
    .bus_rdata   (bus_rdata)
  );

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NUM_CH) begin : g_live
      ch_flags_t fl;
      dma_flag_chan chan_i (
        .clk     (clk),
        .rst     (rst),
        .ev_err  (ev_err[c]),
        .ev_half (ev_half[c]),
        .ev_done (ev_done[c]),
        .clr     (ch_flags_t'(clr_word[c*NIB_W +: NIB_W])),
        .en_err  (en_err[c]),
        .en_half (en_half[c]),
        .en_done (en_done[c]),
        .flags   (fl),
        .irq     (irq[c])
      );
      assign stat_nib[c] = fl;
    end else begin : g_absent
      assign stat_nib[c] = '0;
    end
  end

  a_r8_status_write_inert: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == STATUS_ADDR && ev_err == '0 && ev_half == '0 && ev_done == '0)
    |=> $stable(status_word));
endmodule

// File: tb/dma_flag_bank_tb_top.sv
module dma_flag_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h0;
  localparam logic [7:0] A_CLR  = 8'h4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata7, rdata5;
  logic [6:0]  ev_err = '0, ev_half = '0, ev_done = '0;
  logic [6:0]  en_err = '0, en_half = '0, en_done = '0;
  logic [6:0]  irq7;
  logic [4:0]  irq5;
  logic [31:0] got7, got5;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_flag_bank #(.NUM_CH(7)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata7), .ev_err(ev_err), .ev_half(ev_half),
    .ev_done(ev_done), .en_err(en_err), .en_half(en_half), .en_done(en_done), .irq(irq7));

  dma_flag_bank #(.NUM_CH(5)) dut5_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata5), .ev_err(ev_err[4:0]), .ev_half(ev_half[4:0]),
    .ev_done(ev_done[4:0]), .en_err(en_err[4:0]), .en_half(en_half[4:0]),
    .en_done(en_done[4:0]), .irq(irq5));

  function automatic logic [31:0] nib(int ch, logic [3:0] v);
    return {28'h0, v} << (4*ch);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; got7 = rdata7; got5 = rdata5;
  endtask

  task automatic pulse(logic [6:0] e, logic [6:0] h, logic [6:0] d);
    @(negedge clk); ev_err = e; ev_half = h; ev_done = d;
    @(negedge clk); ev_err = '0; ev_half = '0; ev_done = '0;
  endtask

  task automatic t_reset();
    chk("R1 irq7", {25'h0, irq7}, 32'h0);
    chk("R1 rdata", rdata7, 32'h0);
    rd(A_STAT);
    chk("R1 status", got7, 32'h0);
  endtask

  task automatic t_set();
    pulse(7'h00, 7'h00, 7'h01);
    pulse(7'h00, 7'h04, 7'h00);
    pulse(7'h40, 7'h00, 7'h00);
    rd(A_STAT);
    chk("R3 R4 R2 status7", got7, nib(0,4'h3) | nib(2,4'h5) | nib(6,4'h9));
    chk("R2 absent ch status5", got5, nib(0,4'h3) | nib(2,4'h5));
    rd(A_STAT);
    chk("R3 flags hold", got7, nib(0,4'h3) | nib(2,4'h5) | nib(6,4'h9));
  endtask

  task automatic t_status_write();
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT);
    chk("R8 status write inert", got7, nib(0,4'h3) | nib(2,4'h5) | nib(6,4'h9));
  endtask

  task automatic t_clear();
    wr(A_CLR, nib(0,4'h2));
    rd(A_STAT);
    chk("R5 clear end ch0", got7, nib(0,4'h1) | nib(2,4'h5) | nib(6,4'h9));
    wr(A_CLR, 32'h0);
    rd(A_STAT);
    chk("R5 zero write no effect", got7, nib(0,4'h1) | nib(2,4'h5) | nib(6,4'h9));
    wr(A_CLR, nib(6,4'h1));
    rd(A_STAT);
    chk("R6 summary clears ch6", got7, nib(0,4'h1) | nib(2,4'h5));
    rd(A_CLR);
    chk("R9 clear reads zero", got7, 32'h0);
    wr(A_CLR, 32'h0FFF_FFFF);
    rd(A_STAT);
    chk("R5 clear all", got7, 32'h0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    bus_wr = 1; bus_addr = A_CLR; bus_wdata = nib(1,4'h5); ev_half = 7'h02;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; ev_half = '0;
    rd(A_STAT);
    chk("R7 set beats clear", got7, nib(1,4'h5));
    wr(A_CLR, nib(1,4'h1));
  endtask

  task automatic t_reserved();
    pulse(7'h7F, 7'h7F, 7'h7F);
    rd(A_STAT);
    chk("R2 bits 31:28 zero", got7, 32'h0FFF_FFFF);
    chk("R2 absent ch 5 and 6 zero", got5, 32'h000F_FFFF);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STAT);
    chk("R6 cleared all", got7, 32'h0);
  endtask

  task automatic t_irq();
    en_done = 7'h08; en_half = 7'h10;
    pulse(7'h00, 7'h00, 7'h18);
    chk("R10 irq enabled ch3 only", {25'h0, irq7}, 32'h08);
    chk("R10 irq5 ch3", {27'h0, irq5}, 32'h08);
    repeat (3) @(negedge clk);
    chk("R10 irq holds", {25'h0, irq7}, 32'h08);
    pulse(7'h00, 7'h10, 7'h00);
    chk("R10 irq half ch4", {25'h0, irq7}, 32'h18);
    wr(A_CLR, nib(3,4'h2));
    chk("R10 irq drops on clear", {25'h0, irq7}, 32'h10);
    wr(A_CLR, 32'h0FFF_FFFF);
    chk("R10 irq all clear", {25'h0, irq7}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_set();
    t_status_write();
    t_clear();
    t_collide();
    t_reserved();
    t_irq();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule